// File: doc/BRIEF.md
# Four-by-Four Crossbar Memory Switch

This block links four processor ports to four memory module ports so that every processor can reach every module. Each processor presents a request, a read/write strobe, an address and write data. The two most significant address bits pick the target module; the remaining low bits travel to that module as its local address.

Every module port has its own round-robin arbiter and its own multiplexer. Each cycle, the arbiter chooses one of the processors that target its module. The multiplexer then drives that processor's local address, write data, write strobe and an enable onto the module port. Because every module decides alone, processors that target different modules are all served in the same cycle.

A processor that loses sees its ready output held low. It must keep its request and operands unchanged until ready rises. A read that is granted in cycle t comes back in cycle t+1: the module's read data is steered to the processor that issued the read, together with a valid flag. The memories are synchronous RAMs that sit outside the block.

Top module: `xbar_mem_switch`

## Requirements
- R1: After reset, ready, read-valid and all module enables are low while no processor requests. Each arbiter starts with its last-granted index at 3, so processor 0 wins the first contention for any module.
- R2: Address bits [ADDR_W-1:ADDR_W-2] select the module. The low ADDR_W-2 bits appear unchanged on that module's address port in the grant cycle.
- R3: In the cycle a processor's ready is high, its target module has enable high, and that module's write strobe equals the processor's write strobe (1 = write, 0 = read). For a write, the module's write data equals the processor's write data. The number of high module enables equals the number of high ready bits.
- R4: A granted read (write strobe 0) raises that processor's read-valid in the next cycle, with read data equal to the module's read data in that cycle. Read-valid never rises after a write or without a granted read.
- R5: Each module grants at most one processor per cycle, and only a processor that requests it.
- R6: Requests from four processors to four distinct modules are all granted in the same cycle.
- R7: Among the processors requesting a module, the grant goes to the first one found by searching upward (with wrap-around) from the index after the one last granted by that module.
- R8: A processor that holds its request stable is granted after at most three cycles of waiting. Four processors contending for one module finish in four cycles.
- R9: A module that no processor addresses keeps its enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| p_req | input | N_PROC | Request per processor |
| p_we | input | N_PROC | Write strobe per processor (1 write, 0 read) |
| p_addr | input | N_PROC*ADDR_W | Address per processor; top two bits select the module |
| p_wdata | input | N_PROC*DATA_W | Write data per processor |
| p_ready | output | N_PROC | Request accepted this cycle |
| p_rvalid | output | N_PROC | Read data valid for this processor |
| p_rdata | output | N_PROC*DATA_W | Read data per processor |
| m_en | output | N_MEM | Module enable |
| m_we | output | N_MEM | Module write strobe |
| m_addr | output | N_MEM*LOC_W | Module-local address |
| m_wdata | output | N_MEM*DATA_W | Module write data |
| m_rdata | input | N_MEM*DATA_W | Module read data, one cycle after enable |

## Verification
Two things can happen on one module port in the same cycle. The module can return data for the read granted to one processor in the previous cycle while it grants a new access to a different processor. Contention batches provoke this: all four processors target one module with a mix of reads and writes, so the grants arrive back to back. A scoreboard predicts the owner of each returned word and its value from its own shadow memory and its own round-robin model. It then checks that the data reaches only the reader, one cycle after that reader's grant, while the new grant's signals appear on the module port.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic {
    XB_READ  = 1'b0,
    XB_WRITE = 1'b1
  } xb_op_e;

  // index advance with wrap for rotating priority searches
  function automatic int rr_wrap(int idx, int n);
    return (idx >= n) ? idx - n : idx;
  endfunction

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int ADDR_W = 10,
  parameter int N_MEM  = 4,
  localparam int MSEL_W = (N_MEM > 1) ? $clog2(N_MEM) : 1
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_MEM-1:0]  hit
);

  function automatic logic [MSEL_W-1:0] module_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: MSEL_W];
  endfunction

  always_comb begin
    hit = '0;
    hit[module_of(addr)] = req;
  end

endmodule

// File: rtl/xbar_rr_arbiter.sv
module xbar_rr_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);

  logic [IW-1:0] last_q;

  // returns {found, index}; search starts one past the last winner
  function automatic logic [IW:0] rr_pick(logic [N-1:0] r, logic [IW-1:0] last);
    logic          found;
    logic [IW-1:0] idx;
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = xbar_pkg::rr_wrap(int'(last) + k, N);
      if (!found && r[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
    return {found, idx};
  endfunction

  assign {gnt_any, gnt_idx} = rr_pick(req, last_q);

  always_comb begin
    gnt = '0;
    if (gnt_any) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IW'(N - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end

endmodule

// File: rtl/xbar_port_mux.sv
module xbar_port_mux #(
  parameter int N_PROC = 4,
  parameter int LOC_W  = 8,
  parameter int DATA_W = 16,
  localparam int IW = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
  input  logic                     gnt_any,
  input  logic [IW-1:0]            sel,
  input  logic [N_PROC*LOC_W-1:0]  loc_addr,
  input  logic [N_PROC-1:0]        we,
  input  logic [N_PROC*DATA_W-1:0] wdata,
  output logic                     m_en,
  output logic                     m_we,
  output logic [LOC_W-1:0]         m_addr,
  output logic [DATA_W-1:0]        m_wdata
);

  always_comb begin
    m_en    = gnt_any;
    m_we    = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    if (gnt_any) begin
      m_we    = we[sel];
      m_addr  = loc_addr[int'(sel)*LOC_W +: LOC_W];
      m_wdata = wdata[int'(sel)*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/xbar_rd_return.sv
module xbar_rd_return #(
  parameter int N_PROC = 4,
  parameter int N_MEM  = 4,
  parameter int DATA_W = 16,
  localparam int IW = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_MEM-1:0]         rd_fire,
  input  logic [N_MEM*IW-1:0]      rd_who,
  input  logic [N_MEM*DATA_W-1:0]  m_rdata,
  output logic [N_PROC-1:0]        p_rvalid,
  output logic [N_PROC*DATA_W-1:0] p_rdata
);

  logic [N_MEM-1:0]    vld_q;
  logic [N_MEM*IW-1:0] who_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      who_q <= '0;
    end else begin
      vld_q <= rd_fire;
      who_q <= rd_who;
    end
  end

  // a processor holds at most one grant per cycle, so no two modules collide
  always_comb begin
    p_rvalid = '0;
    p_rdata  = '0;
    for (int m = 0; m < N_MEM; m++) begin
      if (vld_q[m]) begin
        p_rvalid[who_q[m*IW +: IW]] = 1'b1;
        p_rdata[int'(who_q[m*IW +: IW])*DATA_W +: DATA_W] = m_rdata[m*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/xbar_mem_switch.sv
module xbar_mem_switch
  import xbar_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_MEM  = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int MSEL_W = (N_MEM > 1) ? $clog2(N_MEM) : 1,
  localparam int LOC_W  = ADDR_W - MSEL_W,
  localparam int IW     = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PROC-1:0]        p_req,
  input  logic [N_PROC-1:0]        p_we,
  input  logic [N_PROC*ADDR_W-1:0] p_addr,
  input  logic [N_PROC*DATA_W-1:0] p_wdata,
  output logic [N_PROC-1:0]        p_ready,
  output logic [N_PROC-1:0]        p_rvalid,
  output logic [N_PROC*DATA_W-1:0] p_rdata,
  output logic [N_MEM-1:0]         m_en,
  output logic [N_MEM-1:0]         m_we,
  output logic [N_MEM*LOC_W-1:0]   m_addr,
  output logic [N_MEM*DATA_W-1:0]  m_wdata,
  input  logic [N_MEM*DATA_W-1:0]  m_rdata
);

  // observable internal events (row m holds module m's view of all processors)
  logic [N_MEM-1:0]        hit_p [N_PROC];
  logic [N_PROC*LOC_W-1:0] loc_flat;
  logic [N_MEM*N_PROC-1:0] req_flat;
  logic [N_MEM*N_PROC-1:0] gnt_flat;
  logic [N_MEM*IW-1:0]     gnt_idx_flat;
  logic [N_MEM-1:0]        gnt_any;
  logic [N_MEM-1:0]        rd_fire;

  for (genvar i = 0; i < N_PROC; i++) begin : g_proc
    xbar_decode #(.ADDR_W(ADDR_W), .N_MEM(N_MEM)) u_dec (
      .req (p_req[i]),
      .addr(p_addr[i*ADDR_W +: ADDR_W]),
      .hit (hit_p[i])
    );
    assign loc_flat[i*LOC_W +: LOC_W] = p_addr[i*ADDR_W +: LOC_W];
    for (genvar m = 0; m < N_MEM; m++) begin : g_route
      assign req_flat[m*N_PROC + i] = hit_p[i][m];
    end
  end

  for (genvar m = 0; m < N_MEM; m++) begin : g_mod
    xbar_rr_arbiter #(.N(N_PROC)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_flat[m*N_PROC +: N_PROC]),
      .gnt    (gnt_flat[m*N_PROC +: N_PROC]),
      .gnt_idx(gnt_idx_flat[m*IW +: IW]),
      .gnt_any(gnt_any[m])
    );
    xbar_port_mux #(.N_PROC(N_PROC), .LOC_W(LOC_W), .DATA_W(DATA_W)) u_mux (
      .gnt_any (gnt_any[m]),
      .sel     (gnt_idx_flat[m*IW +: IW]),
      .loc_addr(loc_flat),
      .we      (p_we),
      .wdata   (p_wdata),
      .m_en    (m_en[m]),
      .m_we    (m_we[m]),
      .m_addr  (m_addr[m*LOC_W +: LOC_W]),
      .m_wdata (m_wdata[m*DATA_W +: DATA_W])
    );
    assign rd_fire[m] = m_en[m] && (xb_op_e'(m_we[m]) == XB_READ);
  end

  always_comb begin
    p_ready = '0;
    for (int m = 0; m < N_MEM; m++)
      p_ready = p_ready | gnt_flat[m*N_PROC +: N_PROC];
  end

  xbar_rd_return #(.N_PROC(N_PROC), .N_MEM(N_MEM), .DATA_W(DATA_W)) u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .rd_who  (gnt_idx_flat),
    .m_rdata (m_rdata),
    .p_rvalid(p_rvalid),
    .p_rdata (p_rdata)
  );

endmodule

// File: rtl/xbar_mem_switch_chk.sv
module xbar_mem_switch_chk #(
  parameter int N_PROC = 4,
  parameter int N_MEM  = 4,
  localparam int CW = $clog2(N_PROC + 1) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_PROC-1:0]       p_req,
  input logic [N_PROC-1:0]       p_we,
  input logic [N_PROC-1:0]       p_ready,
  input logic [N_PROC-1:0]       p_rvalid,
  input logic [N_MEM-1:0]        m_en,
  input logic [N_MEM*N_PROC-1:0] req_flat,
  input logic [N_MEM*N_PROC-1:0] gnt_flat
);

  for (genvar m = 0; m < N_MEM; m++) begin : g_m
    a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_flat[m*N_PROC +: N_PROC]));
    a_r9_idle_module: assert property (@(posedge clk) disable iff (!rst_n)
      m_en[m] |-> (|req_flat[m*N_PROC +: N_PROC]));
  end

  for (genvar k = 0; k < N_MEM*N_PROC; k++) begin : g_k
    a_r5_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_flat[k] |-> req_flat[k]);
  end

  a_r3_enables_match_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(m_en) == $countones(p_ready));

  for (genvar i = 0; i < N_PROC; i++) begin : g_p
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                       wait_q <= '0;
      else if (!p_req[i] || p_ready[i]) wait_q <= '0;
      else if (wait_q != '1)            wait_q <= wait_q + 1'b1;
    end

    a_r4_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ready[i] && !p_we[i]) |=> p_rvalid[i]);
    a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      p_rvalid[i] |-> $past(p_ready[i] && !p_we[i]));
    a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wait_q) <= N_PROC - 1);
  end

endmodule

bind xbar_mem_switch xbar_mem_switch_chk #(.N_PROC(N_PROC), .N_MEM(N_MEM)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .p_req   (p_req),
  .p_we    (p_we),
  .p_ready (p_ready),
  .p_rvalid(p_rvalid),
  .m_en    (m_en),
  .req_flat(req_flat),
  .gnt_flat(gnt_flat)
);

// File: tb/xbar_mem_switch_test.sv
module xbar_mem_switch_test;

  localparam int NP = 4;
  localparam int NM = 4;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int LW = AW - 2;
  localparam int DEPTH = 1 << LW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    p_req = '0;
  logic [NP-1:0]    p_we = '0;
  logic [NP*AW-1:0] p_addr = '0;
  logic [NP*DW-1:0] p_wdata = '0;
  logic [NP-1:0]    p_ready;
  logic [NP-1:0]    p_rvalid;
  logic [NP*DW-1:0] p_rdata;
  logic [NM-1:0]    m_en;
  logic [NM-1:0]    m_we;
  logic [NM*LW-1:0] m_addr;
  logic [NM*DW-1:0] m_wdata;
  logic [NM*DW-1:0] m_rdata;

  always #2 clk = ~clk;

  xbar_mem_switch #(.N_PROC(NP), .N_MEM(NM), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_ready(p_ready), .p_rvalid(p_rvalid), .p_rdata(p_rdata),
    .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  // behavioural memory modules with one-cycle read latency
  logic [DW-1:0] ram [NM][DEPTH];
  logic [DW-1:0] shadow [NM][DEPTH];

  function automatic logic [DW-1:0] seed_word(int m, int k);
    return DW'(m * DEPTH + k) ^ 16'hA5A5;
  endfunction

  always @(posedge clk) begin
    for (int m = 0; m < NM; m++) begin
      if (m_en[m]) begin
        if (m_we[m]) ram[m][m_addr[m*LW +: LW]] <= m_wdata[m*DW +: DW];
        else         m_rdata[m*DW +: DW] <= ram[m][m_addr[m*LW +: LW]];
      end
    end
  end

  int total = 0;
  int bad = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { int p; logic [DW-1:0] d; } item_t;
  item_t sb[$];

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [NP-1:0] ev;
      logic [DW-1:0] ed [NP];
      ev = '0;
      for (int i = 0; i < NP; i++) ed[i] = '0;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        ev[it.p] = 1'b1;
        ed[it.p] = it.d;
      end
      for (int i = 0; i < NP; i++)
        chk(p_rvalid[i] == ev[i] && (!ev[i] || p_rdata[i*DW +: DW] == ed[i]),
            $sformatf("R4 read return proc%0d", i),
            {47'd0, p_rvalid[i], p_rdata[i*DW +: DW]}, {47'd0, ev[i], ed[i]});
    end
  end

  // pending operations held by each processor until granted
  bit            pv [NP];
  bit            pwe [NP];
  int            pmod [NP];
  int            ploc [NP];
  logic [DW-1:0] pdat [NP];
  int            last_m [NM];
  int            wt [NP];
  int            maxwait;
  logic [NP-1:0] last_ready;

  task automatic set_op(int i, bit we, int m, int loc, logic [DW-1:0] d);
    pv[i] = 1'b1; pwe[i] = we; pmod[i] = m; ploc[i] = loc; pdat[i] = d; wt[i] = 0;
  endtask

  task automatic drive_cycle();
    int win [NM];
    logic [NP-1:0] exp_rdy;
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      p_req[i] = pv[i];
      p_we[i]  = pwe[i];
      p_addr[i*AW +: AW]  = {2'(pmod[i]), LW'(ploc[i])};
      p_wdata[i*DW +: DW] = pdat[i];
    end
    #1;
    exp_rdy = '0;
    for (int m = 0; m < NM; m++) begin
      win[m] = -1;
      for (int k = 1; k <= NP; k++) begin
        int j;
        j = (last_m[m] + k) % NP;
        if (win[m] < 0 && pv[j] && pmod[j] == m) win[m] = j;
      end
      if (win[m] >= 0) exp_rdy[win[m]] = 1'b1;
    end
    chk(p_ready == exp_rdy, "R5 R7 grant vector", 64'(p_ready), 64'(exp_rdy));
    last_ready = p_ready;
    for (int m = 0; m < NM; m++) begin
      if (win[m] >= 0) begin
        int w;
        w = win[m];
        chk(m_en[m] && m_we[m] == pwe[w] && int'(m_addr[m*LW +: LW]) == ploc[w]
            && (!pwe[w] || m_wdata[m*DW +: DW] == pdat[w]),
            $sformatf("R2 R3 module%0d port", m),
            {30'd0, m_en[m], m_we[m], 8'(m_addr[m*LW +: LW]), m_wdata[m*DW +: DW]},
            {30'd0, 1'b1, pwe[w], 8'(ploc[w]), pdat[w]});
        last_m[m] = w;
        if (pwe[w]) shadow[m][ploc[w]] = pdat[w];
        else        sb.push_back('{p: w, d: shadow[m][ploc[w]]});
      end else begin
        chk(m_en[m] == 1'b0, $sformatf("R9 idle module%0d", m), 64'(m_en[m]), 64'd0);
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (pv[i] && exp_rdy[i]) pv[i] = 1'b0;
      else if (pv[i]) begin
        wt[i]++;
        if (wt[i] > maxwait) maxwait = wt[i];
      end
    end
  endtask

  task automatic run_batch(output int cycles);
    cycles = 0;
    maxwait = 0;
    while (pv[0] || pv[1] || pv[2] || pv[3]) begin
      drive_cycle();
      cycles++;
    end
    chk(maxwait <= NP - 1, "R8 wait bound", 64'(maxwait), 64'(NP - 1));
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired (R8 progress)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] lf;
    for (int m = 0; m < NM; m++) begin
      last_m[m] = NP - 1;
      for (int k = 0; k < DEPTH; k++) begin
        ram[m][k] = seed_word(m, k);
        shadow[m][k] = seed_word(m, k);
      end
    end
    m_rdata = '0;
    for (int i = 0; i < NP; i++) begin pv[i] = 0; pwe[i] = 0; pmod[i] = 0; ploc[i] = 0; pdat[i] = '0; wt[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(p_ready == '0, "R1 reset ready", 64'(p_ready), 0);
    chk(p_rvalid == '0, "R1 reset rvalid", 64'(p_rvalid), 0);
    chk(m_en == '0, "R1 reset enables", 64'(m_en), 0);

    // R1: first contention after reset goes to processor 0
    set_op(3, 1'b1, 0, 7, 16'h3333);
    set_op(0, 1'b1, 0, 9, 16'h0000);
    drive_cycle();
    chk(last_ready == 4'b0001, "R1 first winner", 64'(last_ready), 64'h1);
    run_batch(cyc);

    // R6: four processors to four distinct modules
    for (int i = 0; i < NP; i++) set_op(i, 1'b1, (i + 1) % NM, 3 * i + 1, DW'(16'h1000 + i));
    run_batch(cyc);
    chk(cyc == 1, "R6 parallel writes", 64'(cyc), 1);
    for (int i = 0; i < NP; i++) set_op((i + 2) % NP, 1'b0, (i + 1) % NM, 3 * i + 1, '0);
    run_batch(cyc);
    chk(cyc == 1, "R6 parallel reads", 64'(cyc), 1);

    // R8: all four on one module
    for (int i = 0; i < NP; i++) set_op(i, 1'b1, 2, 40 + i, DW'(16'h2200 + i));
    run_batch(cyc);
    chk(cyc == NP, "R8 full contention length", 64'(cyc), 64'(NP));
    for (int i = 0; i < NP; i++) set_op(i, 1'b0, 2, 43 - i, '0);
    run_batch(cyc);

    // mixed reads and writes on one module, back-to-back grants
    set_op(0, 1'b1, 3, 5, 16'hBEEF);
    set_op(1, 1'b1, 3, 6, 16'hCAFE);
    set_op(2, 1'b0, 3, 5, '0);
    set_op(3, 1'b0, 3, 6, '0);
    run_batch(cyc);
    set_op(1, 1'b0, 1, 200, '0);
    set_op(2, 1'b0, 1, 201, '0);
    run_batch(cyc);

    // pseudo-random traffic
    lf = 16'hACE1;
    for (int b = 0; b < 400; b++) begin
      for (int i = 0; i < NP; i++) begin
        for (int s = 0; s < 5; s++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[0] | lf[5])
          set_op(i, lf[1], lf[3] ? 0 : int'(lf[7:6]), int'(lf[11:8]), lf ^ 16'h5A00);
      end
      run_batch(cyc);
    end

    drive_cycle();
    drive_cycle();
    chk(sb.size() == 0, "R4 scoreboard drained", 64'(sb.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule